// File: doc/BRIEF.md
# Multi-Mode Barrel Shifter

This block moves the bits of a W-bit word by a binary amount from 0 to W-1 positions in a single step. The direction (toward the most or the least significant end) and the fill behaviour are chosen per word. Vacated positions can receive zeros (logical), copies of the sign bit on a rightward move (arithmetic), or the bits that fall off the opposite end (rotate). An enable input forces the result to zero.

The datapath is a chain of log2(W) two-input multiplexer stages. Stage k is steered by bit k of the amount and moves the word by 2^k places. A leftward move reuses the same rightward chain: the word is bit-reversed on entry and reversed back on exit. The result is held in one output register, so each set of inputs appears at `data_o` one clock after it is sampled.

Top module: `mode_barrel_shifter`

## Requirements
- R1: While `rst` is 1 at a rising clock edge, `data_o` becomes all zeros after that edge.
- R2: With `rst` at 0, `data_o` after a rising edge is the result for the inputs sampled at that edge. It changes on every cycle when the inputs change on every cycle.
- R3: When `en_i` is 0, the next `data_o` is all zeros, whatever the data, amount, direction and mode.
- R4: When `en_i` is 1 and `amt_i` is 0, the next `data_o` equals `data_i` in every mode and direction.
- R5: With `mode_i` = 2'b00 (logical) and `dir_i` = 0 (right), the word moves toward bit 0 by `amt_i` places and the top `amt_i` bits are 0.
- R6: With `mode_i` = 2'b00 and `dir_i` = 1 (left), the word moves toward bit W-1 by `amt_i` places and the low `amt_i` bits are 0.
- R7: With `mode_i` = 2'b01 (arithmetic) and `dir_i` = 0, the top `amt_i` bits are copies of the input's bit W-1.
- R8: With `mode_i` = 2'b01 and `dir_i` = 1, the result is the same as the logical left shift, with zeros entering at the bottom.
- R9: With `mode_i` = 2'b10 (rotate), the bits leaving one end re-enter at the other end, in either direction.
- R10: `mode_i` = 2'b11 gives the same result as the logical mode, in both directions.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; output register updates on the rising edge |
| rst | input | 1 | Synchronous active-high reset of the output register |
| en_i | input | 1 | 1 = shift, 0 = force a zero result |
| data_i | input | W | Word to be shifted |
| amt_i | input | log2(W) | Binary shift amount |
| dir_i | input | 1 | 0 = toward bit 0 (right), 1 = toward bit W-1 (left) |
| mode_i | input | 2 | 00 logical, 01 arithmetic, 10 rotate, 11 logical |
| data_o | output | W | Registered shifted word |

## Verification
For W = 8, every data word is run through every amount, direction and mode. Every result is compared with a model built from the language shift operators. The full amount range reaches each mux stage alone and in every combination. Words with the top bit set and cleared separate arithmetic fill from logical fill. Sparse and dense words separate rotation from zero fill. A directed sequence of known words checks the worked values and back-to-back updates. Cycles with the enable cleared and cycles with reset asserted use non-zero data, so a missing gate shows up as a stray bit.

// File: rtl/bshift_pkg.sv
package bshift_pkg;

  typedef enum logic [1:0] {
    MODE_LOGIC  = 2'b00,
    MODE_ARITH  = 2'b01,
    MODE_ROTATE = 2'b10,
    MODE_SPARE  = 2'b11
  } bshift_mode_e;

  localparam logic DIR_RIGHT = 1'b0;
  localparam logic DIR_LEFT  = 1'b1;

endpackage

// File: rtl/bshift_reverse.sv
module bshift_reverse #(
  parameter int W = 8
) (
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  for (genvar i = 0; i < W; i++) begin : g_bit
    assign q[i] = d[W-1-i];
  end

endmodule

// File: rtl/bshift_stage.sv
module bshift_stage #(
  parameter int W    = 8,
  parameter int DIST = 1
) (
  input  logic [W-1:0] d,
  input  logic         sel,
  input  logic         fill,
  input  logic         rot,
  output logic [W-1:0] q
);

  logic [W-1:0] moved;

  always_comb begin
    if (rot) moved = {d[DIST-1:0], d[W-1:DIST]};
    else     moved = {{DIST{fill}}, d[W-1:DIST]};
    q = sel ? moved : d;
  end

endmodule

// File: rtl/bshift_core.sv
module bshift_core
  import bshift_pkg::*;
#(
  parameter int W  = 8,
  parameter int AW = $clog2(W)
) (
  input  logic          en,
  input  logic [W-1:0]  data,
  input  logic [AW-1:0] amt,
  input  logic          dir,
  input  logic [1:0]    mode,
  output logic [W-1:0]  res
);

  bshift_mode_e mode_e;
  logic         fill_bit;
  logic         rot;
  logic [W-1:0] data_rev;
  logic [W-1:0] net_out_rev;
  logic [W-1:0] chain [0:AW];

  always_comb begin
    mode_e   = bshift_mode_e'(mode);
    rot      = (mode_e == MODE_ROTATE);
    fill_bit = (mode_e == MODE_ARITH) && (dir == DIR_RIGHT) && data[W-1];
  end

  bshift_reverse #(.W(W)) u_rev_in  (.d(data),      .q(data_rev));
  bshift_reverse #(.W(W)) u_rev_out (.d(chain[AW]), .q(net_out_rev));

  assign chain[0] = (dir == DIR_LEFT) ? data_rev : data;

  for (genvar k = 0; k < AW; k++) begin : g_stage
    bshift_stage #(.W(W), .DIST(1 << k)) u_stage (
      .d    (chain[k]),
      .sel  (amt[k]),
      .fill (fill_bit),
      .rot  (rot),
      .q    (chain[k+1])
    );
  end

  always_comb begin
    if (!en)                  res = '0;
    else if (dir == DIR_LEFT) res = net_out_rev;
    else                      res = chain[AW];
  end

endmodule

// File: rtl/mode_barrel_shifter.sv
module mode_barrel_shifter #(
  parameter int W = 8
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 en_i,
  input  logic [W-1:0]         data_i,
  input  logic [$clog2(W)-1:0] amt_i,
  input  logic                 dir_i,
  input  logic [1:0]           mode_i,
  output logic [W-1:0]         data_o
);

  localparam int AW = $clog2(W);

  logic [W-1:0] core_res;

  bshift_core #(.W(W), .AW(AW)) u_core (
    .en   (en_i),
    .data (data_i),
    .amt  (amt_i),
    .dir  (dir_i),
    .mode (mode_i),
    .res  (core_res)
  );

  always_ff @(posedge clk) begin
    if (rst) data_o <= '0;
    else     data_o <= core_res;
  end

endmodule

// File: rtl/bshift_chk.sv
module bshift_chk #(
  parameter int W = 8
) (
  input logic                 clk,
  input logic                 rst,
  input logic                 en_i,
  input logic [W-1:0]         data_i,
  input logic [$clog2(W)-1:0] amt_i,
  input logic                 dir_i,
  input logic [1:0]           mode_i,
  input logic [W-1:0]         data_o
);

  assert_reset_zero_R1: assert property (@(posedge clk)
    rst |=> (data_o == '0));

  assert_disable_zero_R3: assert property (@(posedge clk) disable iff (rst)
    !en_i |=> (data_o == '0));

  assert_zero_amount_R4: assert property (@(posedge clk) disable iff (rst)
    (en_i && amt_i == '0) |=> (data_o == $past(data_i)));

  assert_logic_right_top_R5: assert property (@(posedge clk) disable iff (rst)
    (en_i && mode_i == 2'b00 && !dir_i && amt_i != '0) |=> !data_o[W-1]);

  assert_left_bottom_R6: assert property (@(posedge clk) disable iff (rst)
    (en_i && mode_i != 2'b10 && dir_i && amt_i != '0) |=> !data_o[0]);

  assert_arith_sign_R7: assert property (@(posedge clk) disable iff (rst)
    (en_i && mode_i == 2'b01 && !dir_i) |=> (data_o[W-1] == $past(data_i[W-1])));

  assert_rotate_keeps_ones_R9: assert property (@(posedge clk) disable iff (rst)
    (en_i && mode_i == 2'b10) |=> ($countones(data_o) == $countones($past(data_i))));

endmodule

bind mode_barrel_shifter bshift_chk #(.W(W)) u_chk (
  .clk    (clk),
  .rst    (rst),
  .en_i   (en_i),
  .data_i (data_i),
  .amt_i  (amt_i),
  .dir_i  (dir_i),
  .mode_i (mode_i),
  .data_o (data_o)
);

// File: tb/test_mode_barrel_shifter.sv
module test_mode_barrel_shifter;

  localparam int W        = 8;
  localparam int AW       = $clog2(W);
  localparam int CLK_HALF = 5;
  localparam int WATCHDOG = 200000;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          en_i = 1'b0;
  logic [W-1:0]  data_i = '0;
  logic [AW-1:0] amt_i = '0;
  logic          dir_i = 1'b0;
  logic [1:0]    mode_i = 2'b00;
  logic [W-1:0]  data_o;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  logic [W-1:0] exp_q [$];
  string        tag_q [$];

  always #CLK_HALF clk = ~clk;

  mode_barrel_shifter #(.W(W)) i_mode_barrel_shifter (
    .clk(clk), .rst(rst), .en_i(en_i), .data_i(data_i), .amt_i(amt_i),
    .dir_i(dir_i), .mode_i(mode_i), .data_o(data_o)
  );

  function automatic logic [W-1:0] model(input logic [W-1:0] d, input int a,
                                         input logic dir, input logic [1:0] m,
                                         input logic en, input logic r);
    logic [W-1:0] v;
    if (r || !en) return '0;
    case (m)
      2'b01:   v = dir ? (d << a) : W'($signed(d) >>> a);
      2'b10:   v = dir ? ((d << a) | (d >> (W - a))) : ((d >> a) | (d << (W - a)));
      default: v = dir ? (d << a) : (d >> a);
    endcase
    if (a == 0) v = d;
    return v;
  endfunction

  function automatic string tag_for(input int a, input logic dir,
                                    input logic [1:0] m, input logic en);
    if (!en)    return "R3";
    if (a == 0) return "R4";
    case (m)
      2'b00:   return dir ? "R6" : "R5";
      2'b01:   return dir ? "R8" : "R7";
      2'b10:   return "R9";
      default: return "R10";
    endcase
  endfunction

  task automatic drive(input logic [W-1:0] d, input int a, input logic dir,
                       input logic [1:0] m, input logic en, input logic r,
                       input string tag);
    @(negedge clk);
    rst = r; data_i = d; amt_i = AW'(a); dir_i = dir; mode_i = m; en_i = en;
    exp_q.push_back(model(d, a, dir, m, en, r));
    tag_q.push_back(tag);
  endtask

  task automatic drive_lit(input logic [W-1:0] d, input int a, input logic dir,
                           input logic [1:0] m, input logic [W-1:0] lit, input string tag);
    @(negedge clk);
    rst = 1'b0; data_i = d; amt_i = AW'(a); dir_i = dir; mode_i = m; en_i = 1'b1;
    exp_q.push_back(lit);
    tag_q.push_back(tag);
  endtask

  // Monitor: results appear one edge after the inputs are driven
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (exp_q.size() > 0) begin
        logic [W-1:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        checks++;
        if (data_o !== e) begin
          fails++;
          $display("FAIL %s: data_o=%b expected=%b", t, data_o, e);
        end
      end
    end
  end

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: run did not finish, actual=hung expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    // R1: reset holds output at zero even with live inputs
    drive(8'hA5, 1, 1'b1, 2'b10, 1'b1, 1'b1, "R1");
    drive(8'hFF, 0, 1'b0, 2'b00, 1'b1, 1'b1, "R1");

    // Directed worked values on 1100_1010
    drive_lit(8'b1100_1010, 2, 1'b0, 2'b00, 8'b0011_0010, "R5");
    drive_lit(8'b1100_1010, 2, 1'b1, 2'b00, 8'b0010_1000, "R6");
    drive_lit(8'b1100_1010, 2, 1'b0, 2'b01, 8'b1111_0010, "R7");
    drive_lit(8'b1100_1010, 2, 1'b1, 2'b01, 8'b0010_1000, "R8");
    drive_lit(8'b1100_1010, 2, 1'b0, 2'b10, 8'b1011_0010, "R9");
    drive_lit(8'b1100_1010, 2, 1'b1, 2'b10, 8'b0010_1011, "R9");
    drive_lit(8'b1100_1010, 2, 1'b0, 2'b11, 8'b0011_0010, "R10");
    drive_lit(8'b1100_1010, 0, 1'b0, 2'b01, 8'b1100_1010, "R4");

    // R2: back-to-back changing inputs, each result one edge later
    drive_lit(8'h01, 7, 1'b1, 2'b00, 8'h80, "R2");
    drive_lit(8'h80, 7, 1'b0, 2'b01, 8'hFF, "R2");
    drive_lit(8'h80, 7, 1'b0, 2'b00, 8'h01, "R2");
    drive_lit(8'h81, 1, 1'b1, 2'b10, 8'h03, "R2");

    // R3: enable low with dense data in every mode
    for (int m = 0; m < 4; m++) begin
      drive(8'hFF, 3, 1'b0, 2'(m), 1'b0, 1'b0, "R3");
      drive(8'h5A, 0, 1'b1, 2'(m), 1'b0, 1'b0, "R3");
    end

    // Exhaustive sweep: all words, amounts, directions, modes
    for (int m = 0; m < 4; m++) begin
      for (int dr = 0; dr < 2; dr++) begin
        for (int a = 0; a < W; a++) begin
          for (int d = 0; d < (1 << W); d++) begin
            drive(W'(d), a, 1'(dr), 2'(m), 1'b1, 1'b0, tag_for(a, 1'(dr), 2'(m), 1'b1));
          end
        end
      end
    end

    // R1 again: reset mid-run clears the output
    drive(8'hC3, 2, 1'b0, 2'b01, 1'b1, 1'b1, "R1");
    drive(8'hC3, 2, 1'b0, 2'b01, 1'b1, 1'b0, "R7");

    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule